// File: doc/BRIEF.md
# PCI Interrupt Pin Swizzle and ISA Router

This block collects four shared, active-high PCI interrupt request lines and steers each onto one line of a sixteen-line ISA interrupt bus. The request levels are captured in a register stage. Each line then drives the ISA output chosen by its own byte-wide routing register. When several request lines are steered to the same ISA number, that output carries the OR of their levels. A routing value of sixteen or more leaves its line connected to nothing.

A small byte-addressed configuration write port loads the four routing registers. The port takes an 8-bit offset, 8-bit data and a write strobe. The four registers sit at consecutive offsets starting at 0x60, one per request line in index order.

A separate combinational swizzle output serves the bus fabric. Given a device's slot number (the upper five bits of its device/function code) and its interrupt pin, it reports which shared line that pin lands on. The slot number rotates the pin index, so that pins of neighbouring slots spread across all four lines.

Top module: `pirq_router`

## Requirements
- R1: While `rst` is high, and in the cycles after it falls until a routing register is written, `isa_irq` is all zero whatever `req_lvl` holds. Every routing register resets to 0x80.
- R2: `dev_pirq` equals (`dev_pin` + `dev_slot` − 1) mod 4, combinationally, for every slot 0–31 and pin 0–3 (pin 0 is the first interrupt pin; slot 0 pin 0 gives line 3).
- R3: A write with `cfg_we` high at offset 0x60+k (k = 0..3) loads `cfg_wdata` into the routing register of request line k at the clock edge. Its effect on `isa_irq` appears after that edge and not before it.
- R4: A routing value v below 16 steers request line k to ISA output bit v, so `isa_irq[v]` is high while the captured level of line k is high.
- R5: A routing value of 16 or more (for example 0x10, 0x1F, 0x80, 0xFF) connects its line to no output.
- R6: Each `isa_irq[j]` is the OR of the captured levels of all request lines whose routing register holds j.
- R7: An `isa_irq` bit that no request line with a high captured level is steered to is low.
- R8: A write at any offset outside 0x60–0x63, or any cycle with `cfg_we` low, leaves every routing register unchanged. The bench observes this through `isa_irq`.
- R9: `req_lvl` is captured on each clock edge, and the captured levels clear to zero on reset. A change on `req_lvl` reaches `isa_irq` after the next edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_lvl | input | 4 | Request levels of shared lines 0–3 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| dev_slot | input | 5 | Slot number of the device being swizzled |
| dev_pin | input | 2 | Interrupt pin index of that device |
| dev_pirq | output | 2 | Shared line that pin drives |
| isa_irq | output | 16 | ISA interrupt level vector |

## Verification
The bench builds the block with its default parameters: four request lines, sixteen ISA outputs and a register window based at 0x60. With those values, every slot and pin pair of the swizzle can be enumerated exhaustively. The vector table reaches both end ISA numbers (0 and 15), several lines sharing one output, and several disabling values. Directed cases place the register edge precisely: a level change or a routing write is sampled just before and just after the edge it waits on. Writes just outside the window, and strobe-less writes, are shown to leave the routing unchanged.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;

    localparam int unsigned PIRQ_LINES = 4;
    localparam int unsigned PIRQ_IDX_W = $clog2(PIRQ_LINES);
    localparam int unsigned ISA_IRQS   = 16;
    localparam int unsigned ISA_IDX_W  = $clog2(ISA_IRQS);
    localparam int unsigned ROUTE_W    = 8;
    localparam int unsigned OFF_W      = 8;
    localparam int unsigned SLOT_W     = 5;

    localparam logic [OFF_W-1:0]   ROUTE_BASE = 8'h60;
    localparam logic [ROUTE_W-1:0] ROUTE_RST  = 8'h80;

    typedef logic [ROUTE_W-1:0] route_t;

    typedef struct packed {
        logic               we;
        logic [OFF_W-1:0]   off;
        logic [ROUTE_W-1:0] data;
    } cfg_wr_t;

    typedef struct packed {
        logic                 valid;
        logic [ISA_IDX_W-1:0] irq;
    } steer_t;

    function automatic steer_t decode_route(route_t r);
        steer_t s;
        s.valid = (r < route_t'(ISA_IRQS));
        s.irq   = r[ISA_IDX_W-1:0];
        return s;
    endfunction

    function automatic logic [PIRQ_IDX_W-1:0] swizzle(
        logic [SLOT_W-1:0]     slot,
        logic [PIRQ_IDX_W-1:0] pin
    );
        logic [PIRQ_IDX_W-1:0] s;
        s = pin + slot[PIRQ_IDX_W-1:0] - PIRQ_IDX_W'(1);
        return s;
    endfunction

endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
    import pirq_route_pkg::*;
(
    input  logic [SLOT_W-1:0]     slot,
    input  logic [PIRQ_IDX_W-1:0] pin,
    output logic [PIRQ_IDX_W-1:0] pirq
);
    assign pirq = swizzle(slot, pin);
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_route_pkg::*;
#(
    parameter logic [OFF_W-1:0] BASE  = ROUTE_BASE,
    parameter int unsigned      LINES = PIRQ_LINES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  cfg_wr_t                       cfg,
    output logic [LINES-1:0][ROUTE_W-1:0] route_q
);
    for (genvar k = 0; k < LINES; k++) begin : g_line
        localparam logic [OFF_W-1:0] MY_OFF = BASE + OFF_W'(k);
        logic hit;
        assign hit = cfg.we && (cfg.off == MY_OFF);

        always_ff @(posedge clk) begin
            if (rst)      route_q[k] <= ROUTE_RST;
            else if (hit) route_q[k] <= cfg.data;
        end

        // R3: a strobed write at this line's offset lands in its register
        p_route_write_r3: assert property (@(posedge clk) disable iff (rst)
            (cfg.we && cfg.off == MY_OFF) |=> route_q[k] == $past(cfg.data));

        // R8: any other cycle leaves the register as it was
        p_route_hold_r8: assert property (@(posedge clk) disable iff (rst)
            !(cfg.we && cfg.off == MY_OFF) |=> $stable(route_q[k]));
    end
endmodule

// File: rtl/pirq_level_latch.sv
module pirq_level_latch
    import pirq_route_pkg::*;
#(
    parameter int unsigned LINES = PIRQ_LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] req,
    output logic [LINES-1:0] lvl_q
);
    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= req;
    end

    // R9: captured levels trail the inputs by one edge
    p_level_follow_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> lvl_q == $past(req));
endmodule

// File: rtl/pirq_irq_combine.sv
module pirq_irq_combine
    import pirq_route_pkg::*;
#(
    parameter int unsigned LINES = PIRQ_LINES,
    parameter int unsigned IRQS  = ISA_IRQS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [LINES-1:0][ROUTE_W-1:0] route_q,
    input  logic [LINES-1:0]              lvl_q,
    output logic [IRQS-1:0]               irq
);
    steer_t st [LINES];

    for (genvar k = 0; k < LINES; k++) begin : g_dec
        assign st[k] = decode_route(route_q[k]);
    end

    for (genvar j = 0; j < IRQS; j++) begin : g_irq
        logic [LINES-1:0] feed;
        logic [LINES-1:0] chk_feed;
        for (genvar k = 0; k < LINES; k++) begin : g_src
            assign feed[k] = lvl_q[k] && st[k].valid
                             && (st[k].irq == ISA_IDX_W'(j));
            assign chk_feed[k] = lvl_q[k] && (route_q[k] == ROUTE_W'(j));

            // R6: an active line steered here forces this output high
            p_or_r6: assert property (@(posedge clk) disable iff (rst)
                (lvl_q[k] && route_q[k] == ROUTE_W'(j)) |-> irq[j]);
        end
        assign irq[j] = |feed;

        // R7: a high output must have at least one active source
        p_unrouted_low_r7: assert property (@(posedge clk) disable iff (rst)
            irq[j] |-> (chk_feed != '0));
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_route_pkg::*;
#(
    parameter logic [OFF_W-1:0] ROUTE_BASE_P = ROUTE_BASE
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PIRQ_LINES-1:0] req_lvl,
    input  logic                  cfg_we,
    input  logic [OFF_W-1:0]      cfg_off,
    input  logic [ROUTE_W-1:0]    cfg_wdata,
    input  logic [SLOT_W-1:0]     dev_slot,
    input  logic [PIRQ_IDX_W-1:0] dev_pin,
    output logic [PIRQ_IDX_W-1:0] dev_pirq,
    output logic [ISA_IRQS-1:0]   isa_irq
);
    cfg_wr_t                            cfg;
    logic [PIRQ_LINES-1:0][ROUTE_W-1:0] route_q;
    logic [PIRQ_LINES-1:0]              lvl_q;

    assign cfg.we   = cfg_we;
    assign cfg.off  = cfg_off;
    assign cfg.data = cfg_wdata;

    pirq_swizzle u_swz (
        .slot (dev_slot),
        .pin  (dev_pin),
        .pirq (dev_pirq)
    );

    pirq_route_regs #(
        .BASE  (ROUTE_BASE_P),
        .LINES (PIRQ_LINES)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .route_q (route_q)
    );

    pirq_level_latch #(
        .LINES (PIRQ_LINES)
    ) u_lvl (
        .clk   (clk),
        .rst   (rst),
        .req   (req_lvl),
        .lvl_q (lvl_q)
    );

    pirq_irq_combine #(
        .LINES (PIRQ_LINES),
        .IRQS  (ISA_IRQS)
    ) u_comb (
        .clk     (clk),
        .rst     (rst),
        .route_q (route_q),
        .lvl_q   (lvl_q),
        .irq     (isa_irq)
    );

    // R1: the edge after a reset cycle leaves every output low
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> isa_irq == '0);
endmodule

// File: tb/pirq_router_test.sv
module pirq_router_test;
    import pirq_route_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  req_lvl = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_off = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [4:0]  dev_slot = '0;
    logic [1:0]  dev_pin = '0;
    logic [1:0]  dev_pirq;
    logic [15:0] isa_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pirq_router uut (
        .clk(clk), .rst(rst), .req_lvl(req_lvl), .cfg_we(cfg_we),
        .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .dev_slot(dev_slot),
        .dev_pin(dev_pin), .dev_pirq(dev_pirq), .isa_irq(isa_irq)
    );

    typedef struct packed {
        logic [31:0] routes;   // {line3, line2, line1, line0}
        logic [3:0]  lvl;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{32'h0A070503, 4'b1111, 16'h04A8},
        '{32'h0A070503, 4'b0101, 16'h0088},
        '{32'h0B0B0909, 4'b0010, 16'h0200},
        '{32'h0B0B0909, 4'b1100, 16'h0800},
        '{32'h1080000F, 4'b1111, 16'h8001},
        '{32'h0E0E0E0E, 4'b1000, 16'h4000},
        '{32'h0E0E0E0E, 4'b0000, 16'h0000},
        '{32'h0C021FFF, 4'b1111, 16'h1004}
    };

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(logic [7:0] off, logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_off = off; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_routes(logic [31:0] r);
        for (int k = 0; k < 4; k++) cfg_write(8'h60 + 8'(k), r[k*8 +: 8]);
    endtask

    task automatic set_req(logic [3:0] v);
        @(negedge clk);
        req_lvl = v;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state with all requests high
        req_lvl = 4'hF;
        repeat (3) @(negedge clk);
        check("R1 during reset", isa_irq, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 after reset, routes disconnected", isa_irq, 16'h0000);

        // R4 R5 R6 R7: vector table
        for (int i = 0; i < NV; i++) begin
            set_routes(VECS[i].routes);
            set_req(VECS[i].lvl);
            check($sformatf("R6 R4 R5 R7 vector %0d", i), isa_irq, VECS[i].exp);
        end

        // R9: request capture timing
        set_routes(32'h80808003);
        set_req(4'b0000);
        check("R9 idle", isa_irq, 16'h0000);
        @(negedge clk);
        req_lvl = 4'b0001;
        #1;
        check("R9 before edge", isa_irq, 16'h0000);
        @(negedge clk);
        check("R9 after edge", isa_irq, 16'h0008);
        req_lvl = 4'b0000;
        #1;
        check("R9 drop before edge", isa_irq, 16'h0008);
        @(negedge clk);
        check("R9 drop after edge", isa_irq, 16'h0000);

        // R3: routing write timing
        set_req(4'b0001);
        check("R3 initial route", isa_irq, 16'h0008);
        @(negedge clk);
        cfg_we = 1'b1; cfg_off = 8'h60; cfg_wdata = 8'h05;
        #1;
        check("R3 before edge", isa_irq, 16'h0008);
        @(negedge clk);
        cfg_we = 1'b0;
        check("R3 after edge", isa_irq, 16'h0020);

        // R3: last register of the window
        cfg_write(8'h63, 8'h0D);
        set_req(4'b1000);
        check("R3 offset 0x63", isa_irq, 16'h2000);
        set_req(4'b0001);

        // R8: out-of-window offsets and strobe-less cycles
        cfg_write(8'h64, 8'h03);
        check("R8 offset 0x64", isa_irq, 16'h0020);
        cfg_write(8'h5F, 8'h03);
        check("R8 offset 0x5F", isa_irq, 16'h0020);
        cfg_write(8'hE0, 8'h03);
        check("R8 offset 0xE0", isa_irq, 16'h0020);
        @(negedge clk);
        cfg_off = 8'h60; cfg_wdata = 8'h03;
        repeat (2) @(negedge clk);
        check("R8 no strobe", isa_irq, 16'h0020);

        // R5: disable a live line
        cfg_write(8'h60, 8'h10);
        check("R5 value 0x10", isa_irq, 16'h0000);

        // R2: exhaustive swizzle
        for (int s = 0; s < 32; s++) begin
            for (int p = 0; p < 4; p++) begin
                dev_slot = 5'(s);
                dev_pin  = 2'(p);
                #1;
                check($sformatf("R2 slot %0d pin %0d", s, p),
                      16'(dev_pirq), 16'((p + s + 3) % 4));
            end
        end

        finish_run();
    end
endmodule